// File: doc/BRIEF.md
# Prescaled Timer/Counter with Clear-on-Compare

This block is a free-running timer that advances only when a prescaled tick arrives. The tick comes from the system clock, divided by 1, by a middle divisor (8 by default) or by a high divisor (64 by default). The clock source can also be switched off, and the timer then freezes. A width control runs the counter either as an 8-bit timer or as a 16-bit timer.

Two 8-bit compare inputs feed two compare channels in 8-bit mode. In 16-bit mode they join into one 16-bit compare value that only channel A uses. In normal mode the counter counts up to its maximum and wraps to zero. In clear-on-compare mode it also returns to zero on the tick that follows the count reaching the channel-A compare value. Three sticky flags report overflow and the two channel matches. Each flag stays set until its clear strobe is pulsed.

Top module: `ptt_timer`

## Requirements
- R1: After reset, `count` is 0 and `ovf_flag`, `match_a` and `match_b` are all 0.
- R2: With `src_sel` = 2'b00 (source off), `count` holds its value, no flag is set, and the prescaler phase returns to zero.
- R3: `src_sel` = 2'b01 ticks every clock. `src_sel` = 2'b10 ticks once every DIV_MID clocks. `src_sel` = 2'b11 ticks once every DIV_HI clocks. Starting from source off, the first tick with a divisor D comes on the D-th rising edge, and `count` changes only at ticks.
- R4: In normal mode with `wide` = 0, the tick taken at count 0xFF sets `count` to 0 and sets `ovf_flag`.
- R5: With `wide` = 1, the counter spans 16 bits, and the tick taken at count 0xFFFF sets `count` to 0 and sets `ovf_flag`.
- R6: `match_a` sets on a tick taken while the effective count equals the compare value for A. That value is `cmp_a` in 8-bit mode, and {`cmp_b`,`cmp_a`} in 16-bit mode, with `cmp_b` as the high byte.
- R7: `match_b` sets on a tick taken while `wide` = 0 and the low count byte equals `cmp_b`. It never sets while `wide` = 1.
- R8: With `ctc_en` = 1, the tick taken while the effective count equals the channel-A compare value sets `count` to 0 instead of incrementing it. A count above that value still wraps at the maximum.
- R9: Every flag is sticky. A clear strobe held high across a clock edge clears its flag at that edge, unless the flag's set event falls on the same edge, in which case the flag stays set.
- R10: With `wide` = 0, the upper byte of `count` is 0 after any tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 2 | Clock source: 00 off, 01 clk/1, 10 clk/DIV_MID, 11 clk/DIV_HI |
| wide | input | 1 | 1 selects 16-bit operation |
| ctc_en | input | 1 | 1 selects clear-on-compare mode |
| cmp_a | input | 8 | Compare value A; low byte of the merged value in 16-bit mode |
| cmp_b | input | 8 | Compare value B; high byte of the merged value in 16-bit mode |
| clr_ovf | input | 1 | Clear strobe for the overflow flag |
| clr_a | input | 1 | Clear strobe for the channel-A flag |
| clr_b | input | 1 | Clear strobe for the channel-B flag |
| count | output | 16 | Current counter value |
| ovf_flag | output | 1 | Sticky overflow flag |
| match_a | output | 1 | Sticky channel-A compare flag |
| match_b | output | 1 | Sticky channel-B compare flag |

## Verification
The bench targets several corner cases, each with a known failure mode.
- Tick phase after the source is re-enabled: a prescaler that does not restart from zero moves the first increment off the D-th edge.
- Clear strobe on the same edge as the overflow tick: a design that gives the clear priority would drop the overflow.
- Switching from 16-bit to 8-bit with a non-zero upper byte: a design that compares the full word would miss the 0xFF wrap and the matches.
- Clear-on-compare with the count already past the top value: here the count must still wrap at the maximum and not stall.

// File: rtl/ptt_pkg.sv
package ptt_pkg;

    typedef enum logic [1:0] {
        SRC_OFF  = 2'b00,
        SRC_DIV1 = 2'b01,
        SRC_DIVM = 2'b10,
        SRC_DIVH = 2'b11
    } src_e;

    localparam int NUM_FLAGS = 3;
    localparam int FLG_OVF   = 0;
    localparam int FLG_A     = 1;
    localparam int FLG_B     = 2;

endpackage

// File: rtl/ptt_prescaler.sv
module ptt_prescaler
    import ptt_pkg::*;
#(
    parameter int DIV_MID = 8,
    parameter int DIV_HI  = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] src_sel,
    output logic       tick
);
    localparam int PW = $clog2(DIV_HI);
    localparam int MW = $clog2(DIV_MID);

    logic [PW-1:0] phase;
    src_e          src;

    assign src = src_e'(src_sel);

    // phase restarts from zero whenever the source is off
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (src == SRC_OFF) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    always_comb begin
        unique case (src)
            SRC_OFF:  tick = 1'b0;
            SRC_DIV1: tick = 1'b1;
            SRC_DIVM: tick = &phase[MW-1:0];
            SRC_DIVH: tick = &phase;
            default:  tick = 1'b0;
        endcase
    end

endmodule

// File: rtl/ptt_counter.sv
module ptt_counter #(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          wide,
    input  logic          ctc_en,
    input  logic [BW-1:0] cmp_a,
    input  logic [BW-1:0] cmp_b,
    output logic [2*BW-1:0] count,
    output logic          ev_max,
    output logic          ev_a,
    output logic          ev_b
);
    localparam int CW = 2 * BW;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cur;
    logic [CW-1:0] max_v;
    logic [CW-1:0] top_v;
    logic [CW-1:0] cnt_d;
    logic          eq_top;
    logic          eq_max;
    logic          eq_b;

    always_comb begin
        if (wide) begin
            cur   = cnt_q;
            max_v = {CW{1'b1}};
            top_v = {cmp_b, cmp_a};
        end else begin
            cur   = {{BW{1'b0}}, cnt_q[BW-1:0]};
            max_v = {{BW{1'b0}}, {BW{1'b1}}};
            top_v = {{BW{1'b0}}, cmp_a};
        end
        eq_top = (cur == top_v);
        eq_max = (cur == max_v);
        eq_b   = !wide && (cnt_q[BW-1:0] == cmp_b);
        if ((ctc_en && eq_top) || eq_max) begin
            cnt_d = '0;
        end else begin
            cnt_d = cur + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_d;
        end
    end

    assign count  = cnt_q;
    assign ev_max = tick && eq_max;
    assign ev_a   = tick && eq_top;
    assign ev_b   = tick && eq_b;

endmodule

// File: rtl/ptt_flag.sv
module ptt_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic clr,
    output logic flag
);
    // set has priority over clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set_ev) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/ptt_timer.sv
module ptt_timer
    import ptt_pkg::*;
#(
    parameter int BW      = 8,
    parameter int DIV_MID = 8,
    parameter int DIV_HI  = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      src_sel,
    input  logic            wide,
    input  logic            ctc_en,
    input  logic [BW-1:0]   cmp_a,
    input  logic [BW-1:0]   cmp_b,
    input  logic            clr_ovf,
    input  logic            clr_a,
    input  logic            clr_b,
    output logic [2*BW-1:0] count,
    output logic            ovf_flag,
    output logic            match_a,
    output logic            match_b
);
    logic                 tick;
    logic [NUM_FLAGS-1:0] set_v;
    logic [NUM_FLAGS-1:0] clr_v;
    logic [NUM_FLAGS-1:0] flg_v;

    ptt_prescaler #(
        .DIV_MID (DIV_MID),
        .DIV_HI  (DIV_HI)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_sel (src_sel),
        .tick    (tick)
    );

    ptt_counter #(
        .BW (BW)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .wide   (wide),
        .ctc_en (ctc_en),
        .cmp_a  (cmp_a),
        .cmp_b  (cmp_b),
        .count  (count),
        .ev_max (set_v[FLG_OVF]),
        .ev_a   (set_v[FLG_A]),
        .ev_b   (set_v[FLG_B])
    );

    assign clr_v[FLG_OVF] = clr_ovf;
    assign clr_v[FLG_A]   = clr_a;
    assign clr_v[FLG_B]   = clr_b;

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        ptt_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_ev (set_v[g]),
            .clr    (clr_v[g]),
            .flag   (flg_v[g])
        );
    end

    assign ovf_flag = flg_v[FLG_OVF];
    assign match_a  = flg_v[FLG_A];
    assign match_b  = flg_v[FLG_B];

endmodule

// File: rtl/ptt_timer_chk.sv
module ptt_timer_chk #(
    parameter int BW = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      src_sel,
    input logic            wide,
    input logic            ctc_en,
    input logic [BW-1:0]   cmp_a,
    input logic [BW-1:0]   cmp_b,
    input logic            clr_ovf,
    input logic            clr_a,
    input logic            clr_b,
    input logic [2*BW-1:0] count,
    input logic            ovf_flag,
    input logic            match_a,
    input logic            match_b,
    input logic            tick
);
    logic [2*BW-1:0] eff_cnt;
    logic [2*BW-1:0] eff_top;
    assign eff_cnt = wide ? count : {{BW{1'b0}}, count[BW-1:0]};
    assign eff_top = wide ? {cmp_b, cmp_a} : {{BW{1'b0}}, cmp_a};

    a_r2_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == 2'b00) |=> $stable(count));

    a_r2_stopped_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == 2'b00) && !ovf_flag |=> !ovf_flag);

    a_r4_ovf_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> $past(tick));

    a_r6_match_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(match_a) |-> $past(tick));

    a_r7_b_quiet_wide: assert property (@(posedge clk) disable iff (!rst_n)
        wide && !match_b |=> !match_b);

    a_r8_ctc_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ctc_en && tick && (eff_cnt == eff_top) |=> (count == '0));

    a_r9_sticky_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag && !clr_ovf |=> ovf_flag);

    a_r9_clear_a: assert property (@(posedge clk) disable iff (!rst_n)
        clr_a && !tick |=> !match_a);

    a_r9_clear_b: assert property (@(posedge clk) disable iff (!rst_n)
        clr_b && !tick |=> !match_b);

    a_r10_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !wide && tick |=> (count[2*BW-1:BW] == '0));

endmodule

bind ptt_timer ptt_timer_chk #(.BW(BW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_sel  (src_sel),
    .wide     (wide),
    .ctc_en   (ctc_en),
    .cmp_a    (cmp_a),
    .cmp_b    (cmp_b),
    .clr_ovf  (clr_ovf),
    .clr_a    (clr_a),
    .clr_b    (clr_b),
    .count    (count),
    .ovf_flag (ovf_flag),
    .match_a  (match_a),
    .match_b  (match_b),
    .tick     (tick)
);

// File: tb/ptt_timer_tb.sv
module ptt_timer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  src_sel = 2'b00;
    logic        wide = 1'b0;
    logic        ctc_en = 1'b0;
    logic [7:0]  cmp_a = 8'h00;
    logic [7:0]  cmp_b = 8'h00;
    logic        clr_ovf = 1'b0;
    logic        clr_a = 1'b0;
    logic        clr_b = 1'b0;
    logic [15:0] count;
    logic        ovf_flag;
    logic        match_a;
    logic        match_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ptt_timer u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_sel  (src_sel),
        .wide     (wide),
        .ctc_en   (ctc_en),
        .cmp_a    (cmp_a),
        .cmp_b    (cmp_b),
        .clr_ovf  (clr_ovf),
        .clr_a    (clr_a),
        .clr_b    (clr_b),
        .count    (count),
        .ovf_flag (ovf_flag),
        .match_a  (match_a),
        .match_b  (match_b)
    );

    // ---------------- reference model ----------------
    logic [5:0]  m_pre;
    logic [15:0] m_cnt;
    logic        m_ovf, m_a, m_b;

    function automatic logic exp_tick(logic [1:0] s, logic [5:0] p);
        case (s)
            2'b00:   return 1'b0;
            2'b01:   return 1'b1;
            2'b10:   return (p[2:0] == 3'd7);
            default: return (p == 6'd63);
        endcase
    endfunction

    function automatic logic [15:0] exp_eff(logic [15:0] c, logic w);
        return w ? c : {8'h00, c[7:0]};
    endfunction

    function automatic logic [15:0] exp_next(logic [15:0] c, logic w, logic ctc,
                                             logic [7:0] a, logic [7:0] b);
        logic [15:0] e, top, mx;
        e   = exp_eff(c, w);
        top = w ? {b, a} : {8'h00, a};
        mx  = w ? 16'hFFFF : 16'h00FF;
        if ((ctc && e == top) || e == mx) return 16'h0000;
        return e + 16'd1;
    endfunction

    always @(posedge clk or negedge rst_n) begin : mdl
        logic        t, s_ovf, s_a, s_b;
        logic [15:0] e;
        if (!rst_n) begin
            m_pre <= '0; m_cnt <= '0; m_ovf <= 1'b0; m_a <= 1'b0; m_b <= 1'b0;
        end else begin
            t = exp_tick(src_sel, m_pre);
            e = exp_eff(m_cnt, wide);
            s_ovf = t && (e == (wide ? 16'hFFFF : 16'h00FF));
            s_a   = t && (e == (wide ? {cmp_b, cmp_a} : {8'h00, cmp_a}));
            s_b   = t && !wide && (m_cnt[7:0] == cmp_b);
            m_pre <= (src_sel == 2'b00) ? 6'd0 : m_pre + 6'd1;
            if (t) m_cnt <= exp_next(m_cnt, wide, ctc_en, cmp_a, cmp_b);
            m_ovf <= s_ovf ? 1'b1 : (clr_ovf ? 1'b0 : m_ovf);
            m_a   <= s_a   ? 1'b1 : (clr_a   ? 1'b0 : m_a);
            m_b   <= s_b   ? 1'b1 : (clr_b   ? 1'b0 : m_b);
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // continuous comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(count == m_cnt, "R3 count vs model", count, m_cnt);
            chk(ovf_flag == m_ovf, "R4 ovf_flag vs model", {15'd0, ovf_flag}, {15'd0, m_ovf});
            chk(match_a == m_a, "R6 match_a vs model", {15'd0, match_a}, {15'd0, m_a});
            chk(match_b == m_b, "R7 match_b vs model", {15'd0, match_b}, {15'd0, m_b});
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; src_sel = 2'b00; wide = 1'b0; ctc_en = 1'b0;
        cmp_a = 8'h00; cmp_b = 8'h00; clr_ovf = 1'b0; clr_a = 1'b0; clr_b = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
        finish_run();
    end

    initial begin
        logic [15:0] held;
        void'($urandom(32'd4242));

        // R1 reset state
        do_reset();
        chk(count == 16'h0 && !ovf_flag && !match_a && !match_b, "R1 reset state",
            {count[12:0], ovf_flag, match_a, match_b}, 16'h0);

        // R2 source off holds count
        src_sel = 2'b01; cmp_a = 8'h80; cmp_b = 8'h90;
        step(20);
        src_sel = 2'b00;
        step(1);
        held = count;
        step(15);
        chk(count == held, "R2 count holds with source off", count, held);
        chk(!ovf_flag && !match_a && !match_b, "R2 no flag with source off",
            {13'd0, ovf_flag, match_a, match_b}, 16'h0);

        // R3 divide-by-middle first tick on the 8th edge
        do_reset();
        cmp_a = 8'h80; cmp_b = 8'h90;
        src_sel = 2'b10;
        step(7);
        chk(count == 16'h0, "R3 /8 no step before 8th edge", count, 16'h0);
        step(1);
        chk(count == 16'h1, "R3 /8 step on 8th edge", count, 16'h1);
        step(8);
        chk(count == 16'h2, "R3 /8 second step", count, 16'h2);
        // R3 divide-by-high after re-enabling
        src_sel = 2'b00; step(2);
        src_sel = 2'b11;
        step(63);
        chk(count == 16'h2, "R3 /64 no step before 64th edge", count, 16'h2);
        step(1);
        chk(count == 16'h3, "R3 /64 step on 64th edge", count, 16'h3);

        // R4, R9 8-bit wrap with clear strobe on the same edge; R6 match
        do_reset();
        cmp_a = 8'h80; cmp_b = 8'h90;
        src_sel = 2'b01;
        step(255);
        chk(count == 16'h00FF, "R4 count reaches 0xFF", count, 16'h00FF);
        chk(match_a && match_b, "R6 R7 8-bit matches set", {14'd0, match_a, match_b}, 16'h3);
        clr_ovf = 1'b1;
        step(1);
        chk(count == 16'h0, "R4 wrap to zero", count, 16'h0);
        chk(ovf_flag, "R9 set wins over clear", {15'd0, ovf_flag}, 16'h1);
        step(1);
        chk(!ovf_flag, "R9 clear takes effect", {15'd0, ovf_flag}, 16'h0);
        clr_ovf = 1'b0; clr_a = 1'b1;
        step(1);
        clr_a = 1'b0;
        chk(!match_a && match_b, "R9 clear only its own flag", {14'd0, match_a, match_b}, 16'h1);

        // R8 clear-on-compare
        do_reset();
        ctc_en = 1'b1; cmp_a = 8'h05; cmp_b = 8'hF0;
        src_sel = 2'b01;
        step(5);
        chk(count == 16'h5 && !match_a, "R8 reaches top", count, 16'h5);
        step(1);
        chk(count == 16'h0, "R8 returns to zero after top", count, 16'h0);
        chk(match_a && !ovf_flag, "R6 match at top in ctc", {14'd0, match_a, ovf_flag}, 16'h2);

        // R10 switch 16->8 bit with nonzero upper byte
        do_reset();
        wide = 1'b1; cmp_a = 8'h03; cmp_b = 8'h00;
        src_sel = 2'b01;
        step(300);
        chk(count == 16'd300, "R5 counts past 8 bits", count, 16'd300);
        chk(!match_b, "R7 no channel-B match in 16-bit mode", {15'd0, match_b}, 16'h0);
        chk(match_a, "R6 16-bit match with high byte zero", {15'd0, match_a}, 16'h1);
        wide = 1'b0;
        step(1);
        chk(count[15:8] == 8'h0, "R10 upper byte cleared", count, {8'h0, count[7:0]});

        // R5 16-bit wrap
        do_reset();
        wide = 1'b1; cmp_a = 8'h34; cmp_b = 8'h12;
        src_sel = 2'b01;
        step(16'h1234);
        chk(!match_a, "R6 no 16-bit match before tick", {15'd0, match_a}, 16'h0);
        step(1);
        chk(match_a, "R6 16-bit match high byte from cmp_b", {15'd0, match_a}, 16'h1);
        step(65535 - 16'h1235);
        chk(count == 16'hFFFF && !ovf_flag, "R5 reaches 0xFFFF", count, 16'hFFFF);
        step(1);
        chk(count == 16'h0 && ovf_flag, "R5 16-bit wrap sets overflow", count, 16'h0);

        // random phase, checked against the model
        do_reset();
        for (int i = 0; i < 400; i++) begin
            int r;
            r = $urandom_range(0, 9);
            src_sel = (r < 6) ? 2'b01 : (r < 8) ? 2'b10 : (r < 9) ? 2'b11 : 2'b00;
            wide    = ($urandom_range(0, 3) == 0);
            ctc_en  = $urandom_range(0, 1);
            cmp_a   = 8'($urandom_range(0, 40));
            cmp_b   = wide ? 8'($urandom_range(0, 1)) : 8'($urandom_range(0, 60));
            for (int k = 0; k < 50; k++) begin
                clr_ovf = ($urandom_range(0, 7) == 0);
                clr_a   = ($urandom_range(0, 7) == 0);
                clr_b   = ($urandom_range(0, 7) == 0);
                step(1);
            end
        end
        clr_ovf = 1'b0; clr_a = 1'b0; clr_b = 1'b0;
        step(2);
        finish_run();
    end

endmodule